// File: doc/BRIEF.md
# Banked Cartridge Address Mapper

This block sits between a CPU, a picture processor and two cartridge memories that are larger than the address windows either processor can see. The CPU programs it by writing to addresses in its upper 32 KB window. The mapper decodes these writes into a set of bank registers. It then translates every CPU program read and every picture-processor pattern fetch into a wider physical address.

The CPU window at 0x8000–0xFFFF is split into four 8 KB slots. Two slots can be switched and two are fixed near the top of program memory. A swap bit in the mode register changes which slots are switchable. The 8 KB pattern window is split into eight 1 KB slots. Each of these has an 8-bit bank register that the CPU loads four bits at a time through separate low-nibble and high-nibble ports. Most register ports answer at several aliased addresses. The block also produces the page select for the two internal nametable pages, based on a mirroring mode.

The register state is clocked. Address translation is combinational from the register state and the read address inputs.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset the four CPU slots (0x8000, 0xA000, 0xC000, 0xE000) map to program banks 0, 1, PRG_BANKS-2 and PRG_BANKS-1. Pattern bank register i holds i for i = 0..7, the mode register is 0, and mirroring is vertical (mode 0).
- R2: A write is decoded on its address ANDed with 0xF0CF, so address bits 11:8 and 5:4 never change which port is hit.
- R3: A write to 0x8000 loads the switchable bank. When mode bit 1 is 0 this bank maps to slot 0x8000 and slot 0xC000 holds bank PRG_BANKS-2. When mode bit 1 is 1 the bank maps to slot 0xC000 and slot 0x8000 holds bank PRG_BANKS-2.
- R4: A write to 0xA000 loads the bank for slot 0xA000.
- R5: Slot 0xE000 always maps to bank PRG_BANKS-1.
- R6: A write to 0x9000 sets the mirroring mode from data bits 1:0. The nametable page select is ppuAddr[10] for 0 (vertical), ppuAddr[11] for 1 (horizontal), constant 0 for 2 and constant 1 for 3.
- R7: A write to 0x9002 or 0x9080 loads all 8 bits of the mode register. Only bit 1 (swap) affects the outputs.
- R8: The pattern registers are paired on pages 0xB000, 0xC000, 0xD000 and 0xE000; the page at 0xB000+0x1000·p holds registers 2p and 2p+1. Offset 0x000 is the low-nibble port of the even register. Offsets 0x001, 0x004 and 0x080 are low-nibble ports of the odd register. A low-nibble write replaces bits 3:0 with data bits 3:0 and keeps bits 7:4.
- R9: Offsets 0x002 and 0x040 are high-nibble ports of the even register. Offsets 0x003, 0x006 and 0x0C0 are high-nibble ports of the odd register. A high-nibble write replaces bits 7:4 with data bits 3:0 and keeps bits 3:0.
- R10: The pattern address is {bank register selected by ppuAddr[12:10], ppuAddr[9:0]}. The program address is {slot bank, cpuRdAddr[12:0]}, with the slot chosen by cpuRdAddr[14:13].
- R11: Bank numbers are truncated to the memory sizes. A program bank keeps its low log2(PRG_BANKS) bits and a pattern bank keeps its low log2(CHR_BANKS) bits. Both sizes are powers of two.
- R12: A write whose masked address matches no port (for example 0x8001, 0xB008, 0xF000) changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuWrEn | input | 1 | CPU write strobe, one cycle per write |
| cpuWrAddr | input | 16 | CPU write address |
| cpuWrData | input | 8 | CPU write data |
| cpuRdAddr | input | 16 | CPU program read address |
| ppuAddr | input | 14 | Picture processor address |
| prgAddr | output | log2(PRG_BANKS)+13 | Physical program memory address |
| chrAddr | output | log2(CHR_BANKS)+10 | Physical pattern memory address |
| ntPageSel | output | 1 | Nametable page select |

## Verification
On every cycle the assertions check three things. Any single write reaches at most one register port. The last slot is always pinned to the top bank. A nibble write leaves the other half of its register untouched, and mode writes land in full.

Only the bench scenarios can show the rest: which exact aliases reach which register, the slot movement when swap toggles, the truncation of oversized bank numbers, and that unmatched addresses are inert. The bench shows these by comparing every translated address against a model after each write.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

  localparam int NUM_CHR_REGS = 8;

  typedef enum logic [1:0] {
    MIR_VERT   = 2'd0,
    MIR_HORZ   = 2'd1,
    MIR_ONE_LO = 2'd2,
    MIR_ONE_HI = 2'd3
  } mirror_e;

  typedef struct packed {
    logic                    prgSwLoad;
    logic                    prgMidLoad;
    logic                    mirrorLoad;
    logic                    modeLoad;
    logic [NUM_CHR_REGS-1:0] chrLoLoad;
    logic [NUM_CHR_REGS-1:0] chrHiLoad;
  } wr_strobe_t;

endpackage

// File: rtl/mapper_ctrl.sv
module mapper_ctrl
  import mapper_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuWrEn,
  input  logic [15:0] cpuWrAddr,
  output wr_strobe_t stb
);

  localparam logic [15:0] DECODE_MASK = 16'hF0CF;
  localparam int          CHR_PAGES   = NUM_CHR_REGS / 2;

  logic [15:0] maskedAddr;

  always_comb begin
    maskedAddr = cpuWrAddr & DECODE_MASK;
    stb        = '0;
    if (cpuWrEn) begin
      case (maskedAddr)
        16'h8000:          stb.prgSwLoad  = 1'b1;
        16'hA000:          stb.prgMidLoad = 1'b1;
        16'h9000:          stb.mirrorLoad = 1'b1;
        16'h9002, 16'h9080: stb.modeLoad  = 1'b1;
        default: ;
      endcase
      for (int p = 0; p < CHR_PAGES; p++) begin
        if (maskedAddr[15:12] == 4'(4'hB + p)) begin
          case (maskedAddr[11:0])
            12'h000:                    stb.chrLoLoad[2*p]   = 1'b1;
            12'h002, 12'h040:           stb.chrHiLoad[2*p]   = 1'b1;
            12'h001, 12'h004, 12'h080:  stb.chrLoLoad[2*p+1] = 1'b1;
            12'h003, 12'h006, 12'h0C0:  stb.chrHiLoad[2*p+1] = 1'b1;
            default: ;
          endcase
        end
      end
    end
  end

  // A single write can reach at most one register port.
  assert_one_target_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.prgSwLoad, stb.prgMidLoad, stb.mirrorLoad, stb.modeLoad,
              stb.chrLoLoad, stb.chrHiLoad}));

  // Without a write strobe no port is loaded.
  assert_idle_no_load_R12: assert property (@(posedge clk) disable iff (!rstN)
    !cpuWrEn |-> (stb == '0));

endmodule

// File: rtl/mapper_datapath.sv
module mapper_datapath
  import mapper_pkg::*;
#(
  parameter int PRG_BANKS = 16,
  parameter int CHR_BANKS = 128,
  localparam int PRG_W = $clog2(PRG_BANKS),
  localparam int CHR_W = $clog2(CHR_BANKS)
)(
  input  logic             clk,
  input  logic             rstN,
  input  wr_strobe_t       stb,
  input  logic [7:0]       wrData,
  input  logic [15:0]      cpuRdAddr,
  input  logic [13:0]      ppuAddr,
  output logic [PRG_W+12:0] prgAddr,
  output logic [CHR_W+9:0]  chrAddr,
  output logic             ntPageSel
);

  localparam logic [PRG_W-1:0] LAST_BANK   = PRG_W'(PRG_BANKS - 1);
  localparam logic [PRG_W-1:0] PENULT_BANK = PRG_W'(PRG_BANKS - 2);
  localparam int               SEL_W       = $clog2(NUM_CHR_REGS);

  logic [PRG_W-1:0] prgSwBank;
  logic [PRG_W-1:0] prgMidBank;
  logic [7:0]       modeReg;
  mirror_e          mirrorMode;
  logic [7:0]       chrBank [NUM_CHR_REGS];

  logic             swapOn;
  logic [PRG_W-1:0] slotBank;
  logic [SEL_W-1:0] chrSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prgSwBank  <= '0;
      prgMidBank <= PRG_W'(1);
      modeReg    <= '0;
      mirrorMode <= MIR_VERT;
      for (int i = 0; i < NUM_CHR_REGS; i++) chrBank[i] <= 8'(i);
    end else begin
      if (stb.prgSwLoad)  prgSwBank  <= wrData[PRG_W-1:0];
      if (stb.prgMidLoad) prgMidBank <= wrData[PRG_W-1:0];
      if (stb.modeLoad)   modeReg    <= wrData;
      if (stb.mirrorLoad) mirrorMode <= mirror_e'(wrData[1:0]);
      for (int i = 0; i < NUM_CHR_REGS; i++) begin
        if (stb.chrLoLoad[i]) chrBank[i][3:0] <= wrData[3:0];
        if (stb.chrHiLoad[i]) chrBank[i][7:4] <= wrData[3:0];
      end
    end
  end

  assign swapOn = modeReg[1];

  always_comb begin
    case (cpuRdAddr[14:13])
      2'd0:    slotBank = swapOn ? PENULT_BANK : prgSwBank;
      2'd1:    slotBank = prgMidBank;
      2'd2:    slotBank = swapOn ? prgSwBank : PENULT_BANK;
      default: slotBank = LAST_BANK;
    endcase
  end

  assign prgAddr = {slotBank, cpuRdAddr[12:0]};
  assign chrSel  = ppuAddr[12:10];
  assign chrAddr = {chrBank[chrSel][CHR_W-1:0], ppuAddr[9:0]};

  always_comb begin
    case (mirrorMode)
      MIR_VERT:   ntPageSel = ppuAddr[10];
      MIR_HORZ:   ntPageSel = ppuAddr[11];
      MIR_ONE_LO: ntPageSel = 1'b0;
      default:    ntPageSel = 1'b1;
    endcase
  end

  assert_last_slot_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRdAddr[14:13] == 2'd3) |-> (prgAddr[PRG_W+12:13] == LAST_BANK));

  assert_mode_load_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.modeLoad |=> (modeReg == $past(wrData)));

  for (genvar g = 0; g < NUM_CHR_REGS; g++) begin : g_nibChk
    assert_lo_keeps_hi_R8: assert property (@(posedge clk) disable iff (!rstN)
      (stb.chrLoLoad[g] && !stb.chrHiLoad[g]) |=>
        (chrBank[g][7:4] == $past(chrBank[g][7:4])));
    assert_hi_keeps_lo_R9: assert property (@(posedge clk) disable iff (!rstN)
      (stb.chrHiLoad[g] && !stb.chrLoLoad[g]) |=>
        (chrBank[g][3:0] == $past(chrBank[g][3:0])));
  end

endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
  import mapper_pkg::*;
#(
  parameter int PRG_BANKS = 16,
  parameter int CHR_BANKS = 128,
  localparam int PRG_W = $clog2(PRG_BANKS),
  localparam int CHR_W = $clog2(CHR_BANKS)
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpuWrEn,
  input  logic [15:0]      cpuWrAddr,
  input  logic [7:0]       cpuWrData,
  input  logic [15:0]      cpuRdAddr,
  input  logic [13:0]      ppuAddr,
  output logic [PRG_W+12:0] prgAddr,
  output logic [CHR_W+9:0]  chrAddr,
  output logic             ntPageSel
);

  wr_strobe_t stb;

  mapper_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .cpuWrEn   (cpuWrEn),
    .cpuWrAddr (cpuWrAddr),
    .stb       (stb)
  );

  mapper_datapath #(
    .PRG_BANKS (PRG_BANKS),
    .CHR_BANKS (CHR_BANKS)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wrData    (cpuWrData),
    .cpuRdAddr (cpuRdAddr),
    .ppuAddr   (ppuAddr),
    .prgAddr   (prgAddr),
    .chrAddr   (chrAddr),
    .ntPageSel (ntPageSel)
  );

endmodule

// File: tb/cart_bank_mapper_tb.sv
`timescale 1ns/1ps
module cart_bank_mapper_tb_top;

  localparam int PRG_BANKS = 16;
  localparam int CHR_BANKS = 128;
  localparam int PRG_W = $clog2(PRG_BANKS);
  localparam int CHR_W = $clog2(CHR_BANKS);

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             cpuWrEn = 1'b0;
  logic [15:0]      cpuWrAddr = '0;
  logic [7:0]       cpuWrData = '0;
  logic [15:0]      cpuRdAddr = 16'h8000;
  logic [13:0]      ppuAddr = '0;
  logic [PRG_W+12:0] prgAddr;
  logic [CHR_W+9:0]  chrAddr;
  logic             ntPageSel;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // bench model of the programmed state
  int mSw, mMid, mMode, mMirr;
  int mChr [8];

  always #5 clk = ~clk;

  cart_bank_mapper #(.PRG_BANKS(PRG_BANKS), .CHR_BANKS(CHR_BANKS)) dut_i (
    .clk(clk), .rstN(rstN), .cpuWrEn(cpuWrEn), .cpuWrAddr(cpuWrAddr),
    .cpuWrData(cpuWrData), .cpuRdAddr(cpuRdAddr), .ppuAddr(ppuAddr),
    .prgAddr(prgAddr), .chrAddr(chrAddr), .ntPageSel(ntPageSel));

  function automatic int expSlotBank(int slot);
    bit swp = ((mMode >> 1) & 1) != 0;
    case (slot)
      0: return swp ? PRG_BANKS - 2 : mSw;
      1: return mMid;
      2: return swp ? mSw : PRG_BANKS - 2;
      default: return PRG_BANKS - 1;
    endcase
  endfunction

  function automatic bit expNt(int mode, logic [13:0] a);
    case (mode)
      0: return a[10];
      1: return a[11];
      2: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  task automatic report(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    for (int s = 0; s < 4; s++) begin
      logic [12:0] off = 13'($urandom);
      @(negedge clk);
      cpuRdAddr = {1'b1, 2'(s), off};
      #1;
      report({tag, " R10 prg slot"}, prgAddr,
             (longint'(expSlotBank(s)) << 13) | longint'(off));
    end
    for (int c = 0; c < 8; c++) begin
      logic [9:0] off = 10'($urandom);
      @(negedge clk);
      ppuAddr = {1'b0, 3'(c), off};
      #1;
      report({tag, " R10 chr slot"}, chrAddr,
             (longint'(mChr[c] & (CHR_BANKS - 1)) << 10) | longint'(off));
    end
    for (int q = 0; q < 4; q++) begin
      @(negedge clk);
      ppuAddr = 14'h2000 | 14'(q << 10) | 14'($urandom & 14'h3FF);
      #1;
      report({tag, " R6 nametable"}, ntPageSel, expNt(mMirr, ppuAddr));
    end
  endtask

  // update the model from a requirement-level view of the port map
  task automatic modelWrite(logic [15:0] a, logic [7:0] d);
    logic [15:0] m = a & 16'hF0CF;
    if (m == 16'h8000) mSw = d & (PRG_BANKS - 1);
    else if (m == 16'hA000) mMid = d & (PRG_BANKS - 1);
    else if (m == 16'h9000) mMirr = d & 3;
    else if (m == 16'h9002 || m == 16'h9080) mMode = d;
    else if (m[15:12] >= 4'hB && m[15:12] <= 4'hE) begin
      int base = 2 * (int'(m[15:12]) - 11);
      case (m[11:0])
        12'h000: mChr[base] = (mChr[base] & 8'hF0) | (d & 8'h0F);
        12'h002, 12'h040: mChr[base] = (mChr[base] & 8'h0F) | ((d & 8'h0F) << 4);
        12'h001, 12'h004, 12'h080:
          mChr[base+1] = (mChr[base+1] & 8'hF0) | (d & 8'h0F);
        12'h003, 12'h006, 12'h0C0:
          mChr[base+1] = (mChr[base+1] & 8'h0F) | ((d & 8'h0F) << 4);
        default: ;
      endcase
    end
  endtask

  task automatic doWrite(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    cpuWrEn = 1'b1; cpuWrAddr = a; cpuWrData = d;
    @(negedge clk);
    cpuWrEn = 1'b0;
    modelWrite(a, d);
  endtask

  function automatic logic [15:0] pickAddr();
    logic [15:0] base;
    int k = $urandom_range(0, 24);
    case (k)
      0: base = 16'h8000;  1: base = 16'hA000;  2: base = 16'h9000;
      3: base = 16'h9002;  4: base = 16'h9080;  5: base = 16'h8001;
      6: base = 16'hF000;  7: base = 16'hB008;  8: base = 16'h9040;
      default: begin
        logic [11:0] offs [9] = '{12'h000, 12'h002, 12'h040, 12'h001, 12'h004,
                                 12'h080, 12'h003, 12'h006, 12'h0C0};
        base = {4'(4'hB + $urandom_range(0, 3)), offs[$urandom_range(0, 8)]};
      end
    endcase
    return base | (16'($urandom) & 16'h0F30);
  endfunction

  initial begin
    void'($urandom(32'h5EED_0042));
    mSw = 0; mMid = 1; mMode = 0; mMirr = 0;
    for (int i = 0; i < 8; i++) mChr[i] = i;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    checkAll("R1 reset");

    doWrite(16'h8000, 8'h05);             checkAll("R3 switch bank");
    doWrite(16'h9080, 8'h02);             checkAll("R3 R7 swap on");
    doWrite(16'h9002, 8'hFD);             checkAll("R7 swap off other bits");
    doWrite(16'hA000, 8'h07);             checkAll("R4 middle slot");
    doWrite(16'h8000, 8'hFF);             checkAll("R11 prg truncation");
    for (int m = 0; m < 4; m++) begin
      doWrite(16'h9000, 8'(m | 8'hFC));   checkAll("R6 mirror mode");
    end
    doWrite(16'hB000, 8'h3A);             checkAll("R8 low nibble");
    doWrite(16'hB040, 8'h0C);             checkAll("R9 high nibble alias");
    doWrite(16'hC080, 8'h09);             checkAll("R8 odd low alias");
    doWrite(16'hC0C0, 8'hF6);             checkAll("R9 odd high alias");
    doWrite(16'hE006, 8'h0F);             checkAll("R9 R11 chr truncation");
    doWrite(16'hDF34, 8'h0E);             checkAll("R2 R8 masked alias");
    doWrite(16'h8F30, 8'h03);             checkAll("R2 masked prg");
    doWrite(16'h8001, 8'h0A);             checkAll("R12 no port 8001");
    doWrite(16'hB008, 8'h0B);             checkAll("R12 no port B008");
    doWrite(16'hF000, 8'h0C);             checkAll("R12 no port F000");
    doWrite(16'hE000, 8'h0D);             checkAll("R5 last slot fixed");

    for (int n = 0; n < 300; n++) begin
      doWrite(pickAddr(), 8'($urandom));
      checkAll("R2 random");
    end

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #1500000;
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule